// File: doc/BRIEF.md
# Four-Mode Barrel Shifter With Count Select

This block is the shift unit of a processor execute stage. Each cycle in which `op_valid` is high, it takes an opcode, a 5-bit count field from the instruction, the operand to shift and the contents of a second register. It produces a 32-bit result and a write-enable for the destination register one clock later. Four operations are provided: logical right, arithmetic right, logical left and circular left.

The count comes from one of two places. A nonzero count field in the instruction is used as the shift amount directly. A count field of zero does not mean "shift by nothing". It tells the unit to take the amount from the low five bits of the second register instead. The shift itself is a logarithmic network of power-of-two stages, followed by a single output register that has a clock enable.

Top module: `shift_top`

## Requirements
- R1: When `cnt_imm` is nonzero, the shift amount is `cnt_imm`, whatever `cnt_reg` holds.
- R2: When `cnt_imm` is zero, the shift amount is `cnt_reg[4:0]`, and bits 31..5 of `cnt_reg` have no effect on `res`.
- R3: Opcode 26 shifts `val_in` right by the amount and fills the vacated upper bits with zeros.
- R4: Opcode 27 shifts `val_in` right by the amount and fills the vacated upper bits with copies of `val_in[31]`. For example, 0x97EAEC16 shifted by 13 gives 0xFFFCBF57.
- R5: Opcode 28 shifts `val_in` left by the amount and fills the vacated lower bits with zeros.
- R6: Opcode 29 rotates `val_in` left by the amount. The low 32-n bits move up, and the top n bits reappear at the bottom.
- R7: A count taken from the register (R2) whose value is 0 returns `val_in` unchanged in all four modes.
- R8: `wr_en` is high in the cycle after an accepted operation whose opcode is 26, 27, 28 or 29. It is low after any other opcode, and low after a cycle in which `op_valid` is low.
- R9: The result appears on `res` at the first rising edge after the operation is presented. `res` keeps its value across cycles in which no shift opcode is accepted.
- R10: While `rst_n` is low, `res` is 0 and `wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 5 | Operation code; 26..29 select the shift modes |
| cnt_imm | input | 5 | Count field from the instruction |
| val_in | input | 32 | Operand to be shifted |
| cnt_reg | input | 32 | Register value whose low 5 bits supply the count when `cnt_imm` is 0 |
| res | output | 32 | Registered shift result |
| wr_en | output | 1 | Destination register write-enable, registered |

## Verification
On every cycle, the assertions check the following:
- the write-enable follows accepted shift opcodes and nothing else;
- `res` holds when no shift is accepted;
- a register-sourced zero count leaves the operand unchanged;
- the sign bit is kept by arithmetic right shifts;
- zeros fill the vacated edge in logical shifts given an immediate count;
- rotation preserves the count of ones.

Exact bit patterns for every amount and mode, including the choice between the two count sources and the disregard of the upper register bits, can only be shown by the bench's scenarios. Those scenarios compare the output against its own reference shifts.

// File: rtl/shift_pkg.sv
`timescale 1ns/1ps
package shift_pkg;
  localparam int OPW = 5;

  localparam logic [OPW-1:0] OPC_SRL = 5'd26;
  localparam logic [OPW-1:0] OPC_SRA = 5'd27;
  localparam logic [OPW-1:0] OPC_SHL = 5'd28;
  localparam logic [OPW-1:0] OPC_ROL = 5'd29;

  typedef enum logic [1:0] {
    MODE_SRL = 2'd0,
    MODE_SRA = 2'd1,
    MODE_SHL = 2'd2,
    MODE_ROL = 2'd3
  } shmode_e;
endpackage

// File: rtl/shift_decode.sv
`timescale 1ns/1ps
module shift_decode
  import shift_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  output logic           is_shift,
  output shmode_e        mode
);
  always_comb begin
    is_shift = 1'b1;
    mode     = MODE_SRL;
    case (opcode)
      OPC_SRL: mode = MODE_SRL;
      OPC_SRA: mode = MODE_SRA;
      OPC_SHL: mode = MODE_SHL;
      OPC_ROL: mode = MODE_ROL;
      default: is_shift = 1'b0;
    endcase
  end
endmodule

// File: rtl/shift_count_sel.sv
`timescale 1ns/1ps
module shift_count_sel #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic [CW-1:0] cnt_imm,
  input  logic [W-1:0]  cnt_reg,
  output logic [CW-1:0] amount
);
  logic unused_reg_hi;
  assign unused_reg_hi = ^cnt_reg[W-1:CW];

  always_comb begin
    if (cnt_imm != '0) amount = cnt_imm;
    else               amount = cnt_reg[CW-1:0];
  end
endmodule

// File: rtl/shift_network.sv
`timescale 1ns/1ps
module shift_network
  import shift_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  shmode_e       mode,
  input  logic [CW-1:0] amount,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout
);
  logic [W-1:0] lvl [0:CW];

  assign lvl[0] = din;

  for (genvar k = 0; k < CW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] moved;
    logic [W-1:0] nxt;

    always_comb begin
      case (mode)
        MODE_SRL: moved = {{S{1'b0}}, lvl[k][W-1:S]};
        MODE_SRA: moved = {{S{lvl[k][W-1]}}, lvl[k][W-1:S]};
        MODE_SHL: moved = {lvl[k][W-1-S:0], {S{1'b0}}};
        default:  moved = {lvl[k][W-1-S:0], lvl[k][W-1:W-S]};
      endcase
      nxt = amount[k] ? moved : lvl[k];
    end

    assign lvl[k+1] = nxt;
  end

  assign dout = lvl[CW];
endmodule

// File: rtl/shift_top.sv
`timescale 1ns/1ps
module shift_top
  import shift_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [OPW-1:0] opcode,
  input  logic [4:0]     cnt_imm,
  input  logic [W-1:0]   val_in,
  input  logic [W-1:0]   cnt_reg,
  output logic [W-1:0]   res,
  output logic           wr_en
);
  localparam int CW = $clog2(W);

  logic          is_shift;
  shmode_e       mode;
  logic [CW-1:0] amount;
  logic [W-1:0]  shifted;
  logic          take;
  logic [W-1:0]  res_d;
  logic          we_d;

  shift_decode u_dec (
    .opcode   (opcode),
    .is_shift (is_shift),
    .mode     (mode)
  );

  shift_count_sel #(.W(W), .CW(CW)) u_cnt (
    .cnt_imm (cnt_imm[CW-1:0]),
    .cnt_reg (cnt_reg),
    .amount  (amount)
  );

  shift_network #(.W(W), .CW(CW)) u_net (
    .mode   (mode),
    .amount (amount),
    .din    (val_in),
    .dout   (shifted)
  );

  assign take = op_valid & is_shift;

  always_comb begin
    res_d = res;
    we_d  = take;
    if (take) res_d = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res   <= '0;
      wr_en <= 1'b0;
    end else begin
      wr_en <= we_d;
      if (take) res <= res_d;
    end
  end
endmodule

// File: rtl/shift_top_chk.sv
`timescale 1ns/1ps
module shift_top_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [4:0]  opcode,
  input logic [4:0]  cnt_imm,
  input logic [31:0] val_in,
  input logic [31:0] cnt_reg,
  input logic [31:0] res,
  input logic        wr_en
);
  logic acc_shift;
  assign acc_shift = op_valid && (opcode >= 5'd26) && (opcode <= 5'd29);

  always @(posedge clk) begin
    if (!rst_n) assert_reset_R10: assert (res == '0 && !wr_en);
  end

  assert_we_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(acc_shift));

  assert_we_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_shift |=> wr_en);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_shift |=> $stable(res));

  assert_zero_reg_cnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_shift && cnt_imm == 5'd0 && cnt_reg[4:0] == 5'd0) |=> res == $past(val_in));

  assert_sign_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 5'd27) |=> res[31] == $past(val_in[31]));

  assert_srl_top_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 5'd26 && cnt_imm != 5'd0) |=> !res[31]);

  assert_shl_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 5'd28 && cnt_imm != 5'd0) |=> !res[0]);

  assert_rol_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 5'd29) |=> $countones(res) == $countones($past(val_in)));
endmodule

bind shift_top shift_top_chk u_chk (.*);

// File: tb/shift_top_tb.sv
`timescale 1ns/1ps
module shift_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [4:0]  opcode;
  logic [4:0]  cnt_imm;
  logic [31:0] val_in;
  logic [31:0] cnt_reg;
  logic [31:0] res;
  logic        wr_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [31:0] exp_res;
  logic        exp_we;

  always #10 clk = ~clk;

  shift_top u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .cnt_imm(cnt_imm), .val_in(val_in), .cnt_reg(cnt_reg),
    .res(res), .wr_en(wr_en)
  );

  function automatic logic [31:0] ref_shift(input logic [4:0] op, input logic [4:0] fld,
                                            input logic [31:0] rc, input logic [31:0] x);
    int n;
    logic [63:0] dbl;
    n = (fld != 5'd0) ? int'(fld) : int'(rc[4:0]);
    dbl = {x, x} << n;
    case (op)
      5'd26:   return x >> n;
      5'd27:   return 32'($signed(x) >>> n);
      5'd28:   return x << n;
      default: return dbl[63:32];
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic run_op(input logic v, input logic [4:0] op, input logic [4:0] fld,
                        input logic [31:0] rc, input logic [31:0] x, input string req);
    op_valid = v; opcode = op; cnt_imm = fld; cnt_reg = rc; val_in = x;
    if (v && op >= 5'd26 && op <= 5'd29) begin
      exp_res = ref_shift(op, fld, rc, x);
      exp_we  = 1'b1;
    end else begin
      exp_we  = 1'b0;
    end
    @(negedge clk);
    check(req, res, exp_res);
    check({req, " wr_en"}, {31'd0, wr_en}, {31'd0, exp_we});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; opcode = '0; cnt_imm = '0; val_in = '0; cnt_reg = '0;
    exp_res = '0; exp_we = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 res", res, 32'd0);
    check("R10 wr_en", {31'd0, wr_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 worked example, immediate count (R1)
    run_op(1, 5'd27, 5'd13, 32'hFFFF_FFFF, 32'h97EA_EC16, "R4 R1 sra example");
    check("R4 value", res, 32'hFFFC_BF57);
    run_op(1, 5'd26, 5'd4,  32'h0000_0007, 32'hF000_000F, "R3 srl");
    run_op(1, 5'd28, 5'd31, 32'h0, 32'h0000_0003, "R5 shl max");
    run_op(1, 5'd29, 5'd8,  32'h0, 32'h1234_5678, "R6 rol");
    check("R6 value", res, 32'h3456_7812);
    // R2 register count, upper bits garbage
    run_op(1, 5'd26, 5'd0, 32'hABCD_EF03, 32'h8000_0000, "R2 srl reg count");
    check("R2 value", res, 32'h1000_0000);
    run_op(1, 5'd29, 5'd0, 32'hFFFF_FFE1, 32'h8000_0001, "R2 rol reg count");
    // R7 register count zero, all four modes, upper bits set
    for (int m = 26; m <= 29; m++) begin
      run_op(1, 5'(m), 5'd0, 32'hFFFF_FFE0, 32'hC3A5_5A3C, "R7 zero reg count");
      check("R7 unchanged", res, 32'hC3A5_5A3C);
    end
    // R8 non-shift opcodes, and R9 hold with op_valid low
    run_op(1, 5'd25, 5'd3, 32'h0, 32'h1111_1111, "R8 non-shift opcode");
    run_op(1, 5'd30, 5'd3, 32'h0, 32'h2222_2222, "R8 non-shift opcode");
    run_op(0, 5'd28, 5'd1, 32'h0, 32'h3333_3333, "R9 hold when idle");
    run_op(1, 5'd28, 5'd1, 32'h0, 32'h3333_3333, "R9 one-cycle latency");
    run_op(1, 5'd27, 5'd31, 32'h0, 32'h8000_0000, "R4 sra full fill");

    // Constrained random mix, fixed seed
    void'($urandom(32'd2024));
    for (int i = 0; i < 400; i++) begin
      logic [4:0] op;
      logic [4:0] fld;
      op  = 5'(24 + ($urandom % 8));
      fld = (($urandom % 4) == 0) ? 5'd0 : 5'($urandom);
      run_op((($urandom % 8) != 0), op, fld, $urandom, $urandom, "R1 R2 R3 R5 R6 R8 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule